// File: doc/BRIEF.md
# Pin Configuration Register Bank

This block holds the static pad configuration for every pin of a 32-pin general-purpose port. Each pin owns one register whose lower half carries the pull resistor choice, slew rate, passive filter enable, open-drain enable, drive strength, a three-bit function select and a sticky lock bit. The block drives these fields as plain outputs to the pad ring and the function multiplexers. Software reaches the registers through a simple register bus with a one-cycle write strobe and a one-cycle read strobe.

Besides the per-pin addresses, there are two broadcast addresses, one for each group of sixteen pins. A single broadcast write carries a 16-bit pin mask in its upper half and a configuration value in its lower half. That value goes to every selected pin in the group in one cycle. A pin whose lock bit is set ignores every write, direct or broadcast, until the next reset.

Bus map: word addresses 0 to 31 select pin registers 0 to 31. Address 32 is the broadcast address for pins 0 to 15. Address 33 is the broadcast address for pins 16 to 31. All other addresses are unused.

Top module: `pinctl_bank`

## Requirements
- R1: After reset every pin register is 0, all configuration outputs are 0, and a read of any pin returns 0.
- R2: A write (`wr_en` high for one cycle) to address 0..31 with the pin unlocked replaces that pin's bits 0,1,2,4,5,6,8,9,10,15 with the written value in that cycle; bits 3, 7 and 14:11 stay 0 whatever is written.
- R3: The outputs decode the register fields: `pull_sel` = bits 1:0 (0 none, 2 down, 3 up), `slow_slew` = bit 2, `filt_en` = bit 4, `od_en` = bit 5, `drive_hi` = bit 6, `mux_sel` = bits 10:8 (0 disabled/analog, 1 GPIO, 2..7 alternates), `pin_locked` = bit 15.
- R4: A write replaces the whole field set, including the function select, so a value with bits 10:8 equal to 0 returns the pin to disabled/analog.
- R5: While a pin's bit 15 is set, a direct write to that pin changes none of its bits.
- R6: A set lock bit can only be cleared by reset; writes with bit 15 at 0 leave it set.
- R7: A write to address 32 copies `wdata[15:0]` (masked as in R2) into pin k, for every k in 0..15 with `wdata[16+k]` = 1; other pins are unchanged.
- R8: A write to address 33 copies `wdata[15:0]` into pin 16+k for every k in 0..15 with `wdata[16+k]` = 1; other pins are unchanged.
- R9: Broadcast writes skip locked pins and still update the unlocked pins selected in the same write.
- R10: A read (`rd_en` high for one cycle) of address 0..31 shows the pin's current value on `rdata[15:0]` from the next cycle on, with `rdata[31:16]` = 0; a read of any other address returns 0. `rdata` holds between reads.
- R11: A write to an address above 33 changes no pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 6 | Word address (0..31 pins, 32/33 broadcast) |
| wdata | input | 32 | Write data; upper half is the pin mask on broadcast writes |
| rdata | output | 32 | Read data, registered |
| pull_sel | output | 64 | Pull select, 2 bits per pin |
| slow_slew | output | 32 | Slow slew enable per pin |
| filt_en | output | 32 | Passive filter enable per pin |
| od_en | output | 32 | Open-drain enable per pin |
| drive_hi | output | 32 | High drive strength per pin |
| mux_sel | output | 96 | Function select, 3 bits per pin |
| pin_locked | output | 32 | Lock state per pin |

## Verification
The hardest situation to reach is a broadcast write whose mask covers both a locked pin and an unlocked pin. Only that write shows that the lock skips one pin without stopping the update of the other. The stimulus first locks one pin with a direct write, then issues a broadcast to its group that selects it and a neighbour. Both registers are then read back, and the lock is shown to survive until a reset pulse clears it.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

  localparam int CFG_W     = 16;
  localparam int GROUP_W   = 16;
  // bits that hold state: 15, 10:8, 6:4, 2:0
  localparam logic [CFG_W-1:0] CFG_IMPL_MASK = 16'h8777;

  typedef struct packed {
    logic       lock;      // 15
    logic [3:0] rsv_hi;    // 14:11
    logic [2:0] mux;       // 10:8
    logic       rsv7;      // 7
    logic       drive_hi;  // 6
    logic       od_en;     // 5
    logic       filt_en;   // 4
    logic       rsv3;      // 3
    logic       slow_slew; // 2
    logic [1:0] pull;      // 1:0
  } pin_cfg_t;

endpackage

// File: rtl/pinctl_wr_dec.sv
module pinctl_wr_dec #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [pinctl_pkg::GROUP_W-1:0] grp_mask,
  output logic [NUM_PINS-1:0]           pin_we
);
  import pinctl_pkg::*;

  localparam int NUM_GROUPS = NUM_PINS / GROUP_W;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int GRP = i / GROUP_W;
    localparam int SUB = i % GROUP_W;
    logic hit_direct;
    logic hit_group;
    assign hit_direct = (addr == ADDR_W'(i));
    assign hit_group  = (addr == ADDR_W'(NUM_PINS + GRP)) && grp_mask[SUB];
    assign pin_we[i]  = wr_en && (hit_direct || hit_group);
  end

  if (NUM_GROUPS * GROUP_W != NUM_PINS) begin : g_bad_cfg
    initial $error("NUM_PINS must be a multiple of the group width");
  end

endmodule

// File: rtl/pinctl_pin_reg.sv
module pinctl_pin_reg (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [pinctl_pkg::CFG_W-1:0]   wval,
  output pinctl_pkg::pin_cfg_t           cfg_q
);
  import pinctl_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we && !cfg_q.lock) begin
      cfg_q <= pin_cfg_t'(wval & CFG_IMPL_MASK);
    end
  end

endmodule

// File: rtl/pinctl_rd_mux.sv
module pinctl_rd_mux #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [pinctl_pkg::CFG_W*NUM_PINS-1:0] cfg_flat,
  output logic [31:0]                         rdata
);
  import pinctl_pkg::*;

  logic [CFG_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (addr == ADDR_W'(i)) sel = cfg_flat[CFG_W*i +: CFG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= {{(32-CFG_W){1'b0}}, sel};
    end
  end

endmodule

// File: rtl/pinctl_bank.sv
module pinctl_bank #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [2*NUM_PINS-1:0] pull_sel,
  output logic [NUM_PINS-1:0]   slow_slew,
  output logic [NUM_PINS-1:0]   filt_en,
  output logic [NUM_PINS-1:0]   od_en,
  output logic [NUM_PINS-1:0]   drive_hi,
  output logic [3*NUM_PINS-1:0] mux_sel,
  output logic [NUM_PINS-1:0]   pin_locked
);
  import pinctl_pkg::*;

  logic [NUM_PINS-1:0]       pin_we;
  logic [CFG_W*NUM_PINS-1:0] cfg_flat;

  pinctl_wr_dec #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
    .wr_en    (wr_en),
    .addr     (addr),
    .grp_mask (wdata[31:16]),
    .pin_we   (pin_we)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_cfg_t cfg;
    pinctl_pin_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (pin_we[i]),
      .wval  (wdata[CFG_W-1:0]),
      .cfg_q (cfg)
    );
    assign cfg_flat[CFG_W*i +: CFG_W] = cfg;
    assign pull_sel[2*i +: 2]         = cfg.pull;
    assign slow_slew[i]               = cfg.slow_slew;
    assign filt_en[i]                 = cfg.filt_en;
    assign od_en[i]                   = cfg.od_en;
    assign drive_hi[i]                = cfg.drive_hi;
    assign mux_sel[3*i +: 3]          = cfg.mux;
    assign pin_locked[i]              = cfg.lock;
  end

  pinctl_rd_mux #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (addr),
    .cfg_flat (cfg_flat),
    .rdata    (rdata)
  );

endmodule

// File: rtl/pinctl_bank_chk.sv
module pinctl_bank_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [31:0]           rdata,
  input logic [2*NUM_PINS-1:0] pull_sel,
  input logic [NUM_PINS-1:0]   slow_slew,
  input logic [NUM_PINS-1:0]   filt_en,
  input logic [NUM_PINS-1:0]   od_en,
  input logic [NUM_PINS-1:0]   drive_hi,
  input logic [3*NUM_PINS-1:0] mux_sel,
  input logic [NUM_PINS-1:0]   pin_locked
);

  logic [9*NUM_PINS-1:0] all_cfg;
  assign all_cfg = {pull_sel, slow_slew, filt_en, od_en, drive_hi, mux_sel, pin_locked};

  // R6: a lock bit never falls while out of reset
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pin_locked) & ~pin_locked) == '0));

  // R2: no write strobe, no configuration change
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(all_cfg));

  // R11: writes above the broadcast addresses change nothing
  p_bad_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > ADDR_W'(NUM_PINS + 1)) |=> $stable(all_cfg));

  // R10: upper read half always zero
  p_rd_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:16] == 16'h0);

  // R10: reads outside the pin range return zero
  p_rd_other_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= ADDR_W'(NUM_PINS)) |=> (rdata == 32'h0));

  // R5 / R9: a locked pin keeps every field
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lock
    p_locked_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pin_locked[i] |=> ($stable(pull_sel[2*i +: 2]) && $stable(mux_sel[3*i +: 3]) &&
                         $stable({slow_slew[i], filt_en[i], od_en[i], drive_hi[i], pin_locked[i]})));
  end

endmodule

bind pinctl_bank pinctl_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_pinctl_bank.sv
`timescale 1ns/1ps
module tb_pinctl_bank;
  localparam int N = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [2*N-1:0] pull_sel;
  logic [N-1:0]  slow_slew, filt_en, od_en, drive_hi, pin_locked;
  logic [3*N-1:0] mux_sel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pinctl_bank #(.NUM_PINS(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pull_sel(pull_sel), .slow_slew(slow_slew),
    .filt_en(filt_en), .od_en(od_en), .drive_hi(drive_hi), .mux_sel(mux_sel),
    .pin_locked(pin_locked)
  );

  // {write addr, write data, pin to read, expected read}
  localparam logic [75:0] VEC [8] = '{
    {6'd3,  32'hFFFF_7FFF, 6'd3,  32'h0000_0777},  // R2 unused bits drop
    {6'd3,  32'h0000_0003, 6'd3,  32'h0000_0003},  // R4 mux back to 0
    {6'd32, 32'h0005_0162, 6'd2,  32'h0000_0162},  // R7 pins 0,2
    {6'd40, 32'hFFFF_FFFF, 6'd0,  32'h0000_0162},  // R11 bad address
    {6'd33, 32'h8001_0255, 6'd31, 32'h0000_0255},  // R8 pins 16,31
    {6'd33, 32'h0000_0777, 6'd16, 32'h0000_0255},  // R8 empty mask
    {6'd32, 32'h0008_0701, 6'd3,  32'h0000_0701},  // R7 pin 3
    {6'd20, 32'h0000_0044, 6'd20, 32'h0000_0044}   // R2 direct write
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] rv;
    do_reset();
    // R1 reset state
    check("R1 outputs", {pull_sel[31:0] | pull_sel[63:32] | mux_sel[31:0] | mux_sel[63:32] |
                         mux_sel[95:64] | slow_slew | filt_en | od_en | drive_hi | pin_locked}, 32'h0);
    do_read(6'd7, rv);  check("R1 read pin7", rv, 32'h0);
    do_read(6'd32, rv); check("R10 read broadcast addr", rv, 32'h0);

    for (int v = 0; v < 8; v++) begin
      logic [75:0] e;
      e = VEC[v];
      do_write(e[75:70], e[69:38]);
      do_read(e[37:32], rv);
      check($sformatf("R2/R4/R7/R8/R11 vec%0d", v), rv, e[31:0]);
    end
    do_read(6'd1, rv); check("R7 unselected pin1", rv, 32'h0);
    do_read(6'd17, rv); check("R8 unselected pin17", rv, 32'h0);

    // R3 field decode
    do_write(6'd5, 32'h0000_0573);
    check("R3 pull up", {30'h0, pull_sel[11:10]}, 32'd3);
    check("R3 flags", {28'h0, slow_slew[5], filt_en[5], od_en[5], drive_hi[5]}, 32'h7);
    check("R3 mux", {29'h0, mux_sel[17:15]}, 32'd5);
    do_write(6'd6, 32'h0000_0006);
    check("R3 pull down slow", {29'h0, pull_sel[13:12], slow_slew[6]}, 32'h5);
    check("R3 mux disabled", {29'h0, mux_sel[20:18]}, 32'd0);

    // R5 / R6 / R9 lock behaviour
    do_write(6'd9, 32'h0000_8302);
    check("R5 lock set", {31'h0, pin_locked[9]}, 32'd1);
    do_write(6'd9, 32'h0000_0000);
    do_read(6'd9, rv); check("R5 direct write ignored", rv, 32'h8302);
    check("R6 lock stays", {31'h0, pin_locked[9]}, 32'd1);
    do_write(6'd32, 32'h0600_0101);
    do_read(6'd9, rv);  check("R9 locked pin skipped", rv, 32'h8302);
    do_read(6'd10, rv); check("R9 neighbour written", rv, 32'h0101);
    do_reset();
    check("R6 reset clears lock", {31'h0, pin_locked[9]}, 32'd0);
    do_read(6'd9, rv); check("R1 pin9 after reset", rv, 32'h0);
    do_write(6'd9, 32'h0000_0001);
    do_read(6'd9, rv); check("R6 writable after reset", rv, 32'h0001);

    // R10 rdata holds between reads
    repeat (3) @(negedge clk);
    check("R10 rdata holds", rdata, 32'h0001);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule